// File: doc/BRIEF.md
# Audio DAC Power-Up Anti-Pop Sequencer

This block orders the power-up and power-down of a single-supply audio DAC so that the analog outputs do not click. It takes the chip's synchronous reset, a power-down control bit, a slow-start mode bit and a strobe that pulses once per left/right (sample) clock. From these it drives four outputs:

- an output-clamp enable that ties both outputs to ground;
- a 14-bit code that a DAC-side level generator uses to move the outputs from ground up to the quiescent level;
- an audio enable, which releases the mute;
- a settled flag that reports when no transition is in progress.

With the power-down bit set, the outputs stay clamped at zero. When the bit clears, there are two paths:

- **Fast path:** the sequencer waits a fixed time, about 50 microseconds counted in master-clock cycles, then jumps straight to the quiescent level.
- **Slow path:** it holds the clamp for a fixed number of sample strobes. It then steps the level code up by one per strobe until full scale, and only then releases audio.

Setting the power-down bit at any later time mutes at once. The level then steps back down one per strobe to zero, and the clamp is applied again.

Top module: `dac_popsafe_seq`

## Requirements
- R1: While `rst_n` is low at a clock edge, the outputs after that edge are `clamp_en`=1, `ramp_code`=0, `audio_en`=0 and `ready`=1 (the off state).
- R2: In the off state with `pwr_down`=1, the block stays off: `clamp_en`=1 and `ramp_code`=0, whatever `lr_tick` does.
- R3: When leaving the off state with `slow_mode`=0, `clamp_en` stays 1 and `ramp_code` stays 0 for FAST_CYC = CLK_KHZ*FAST_US/1000 cycles. On edge number FAST_CYC+1, counted from the first edge that sees `pwr_down`=0, `ramp_code` becomes 16383, `clamp_en` becomes 0 and `audio_en` becomes 1.
- R4: When leaving the off state with `slow_mode`=1, the first edge enters the clamp hold. `clamp_en` then falls on the edge of the CLAMP_TICKS-th (default 1000) `lr_tick` seen after that edge, with `ramp_code` still 0.
- R5: During the rise, `ramp_code` goes up by exactly one on each edge with `lr_tick`=1 and does not change otherwise. `audio_en` goes high on the same edge where the code reaches full scale, 16383 (all 14 bits set).
- R6: `pwr_down`=1 seen during the rise or in the running state drops `audio_en` on that edge and holds `ramp_code` there. After that, `ramp_code` goes down by one on each `lr_tick`, and on the edge where it reaches 0, `clamp_en` returns to 1 and `ready` to 1.
- R7: `pwr_down`=1 seen during the fast wait or the clamp hold returns the block to the off state on that edge, with `ready`=1 and `clamp_en`=1.
- R8: When `pwr_down`=1 and `lr_tick`=1 fall on the same edge, power-down wins. A final clamp-hold tick does not start the rise, and a rise tick does not step the code.
- R9: `audio_en` is 1 only in the running state. `ready` is 1 only in the off and running states.
- R10: Once the descent has begun, it runs to 0 even if `pwr_down` returns to 0. The block then passes through the off state for one edge and starts a new sequence.
- R11: `slow_mode` is sampled only when leaving the off state. Changing it later has no effect on the sequence under way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwr_down | input | 1 | Power-down control bit, 1 = keep or return to off |
| slow_mode | input | 1 | 1 = clamp hold and gradual ramp, 0 = short fixed delay |
| lr_tick | input | 1 | One-cycle pulse per sample (left/right) clock |
| clamp_en | output | 1 | Clamp both outputs to ground |
| ramp_code | output | 14 | Quiescent-level code, 0 = ground, 16383 = full level |
| audio_en | output | 1 | Unmute: audio path enabled |
| ready | output | 1 | No transition in progress (off or running) |

## Verification
A sample strobe and a change of the power-down bit can land on the same clock edge. The strobe would finish the clamp hold or step the ramp, while the power-down bit redirects the sequence. The bench raises the power-down bit together with the final clamp-hold strobe, and again together with a strobe in mid-rise.

It judges that power-down has priority in two ways:
- After the final clamp-hold strobe, the block is back in the off state with the code at 0.
- In mid-rise, the code holds its value for that edge and then descends by exactly that many strobes.

// File: rtl/popseq_pkg.sv
// Shared types for the anti-pop power sequencer.
// Assumes: one state register, encoded by the synthesis flow.
package popseq_pkg;
    typedef enum logic [2:0] {
        PS_OFF,    // clamped, level zero, waiting for power-down bit to clear
        PS_FAST,   // short fixed delay, clamp held
        PS_HOLD,   // clamp held for a number of sample strobes
        PS_RISE,   // level climbing one step per strobe
        PS_RUN,    // full level, audio enabled
        PS_FALL    // level descending one step per strobe
    } pseq_state_t;
endpackage

// File: rtl/popseq_evcount.sv
// Event counter: counts qualified events from zero after a clear.
// Assumes: the owner never lets it run past 2**W-1 (limits fit in W bits).
module popseq_evcount #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] count
);
    // Counter register: clear has priority over increment.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            count <= '0;
        else if (inc)
            count <= count + W'(1);
    end
endmodule

// File: rtl/popseq_ramp.sv
// Quiescent-level ramp register: saturating up/down by one, jump to full, clear.
// Assumes: at most one of up/dn/fill is asserted per cycle by the sequencer.
module popseq_ramp #(
    parameter int W = 14
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         fill,
    input  logic         up,
    input  logic         dn,
    output logic [W-1:0] level
);
    localparam logic [W-1:0] LVL_TOP = '1;

    // Level register: saturates at zero and at full scale.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            level <= '0;
        else if (fill)
            level <= LVL_TOP;
        else if (up && level != LVL_TOP)
            level <= level + W'(1);
        else if (dn && level != '0)
            level <= level - W'(1);
    end
endmodule

// File: rtl/popseq_fsm.sv
// Sequencer state machine: orders clamp hold, ramp and audio release,
// and redirects to the descent whenever the power-down bit is set.
// Assumes: lr_tick is a one-cycle pulse; power-down beats a tick on the same edge.
module popseq_fsm
    import popseq_pkg::*;
#(
    parameter int CNT_W       = 10,
    parameter int RAMP_W      = 14,
    parameter int FAST_CYC    = 100,
    parameter int CLAMP_TICKS = 1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_down,
    input  logic              slow_mode,
    input  logic              lr_tick,
    input  logic [CNT_W-1:0]  cnt,
    input  logic [RAMP_W-1:0] level,
    output logic              cnt_clr,
    output logic              cnt_inc,
    output logic              lvl_clr,
    output logic              lvl_fill,
    output logic              lvl_up,
    output logic              lvl_dn,
    output pseq_state_t       state
);
    localparam logic [CNT_W-1:0]  FAST_LAST  = CNT_W'(FAST_CYC - 1);
    localparam logic [CNT_W-1:0]  CLAMP_LAST = CNT_W'(CLAMP_TICKS - 1);
    localparam logic [RAMP_W-1:0] LVL_TOP    = '1;
    localparam logic [RAMP_W-1:0] LVL_PEN    = LVL_TOP - RAMP_W'(1);
    localparam logic [RAMP_W-1:0] LVL_ONE    = RAMP_W'(1);

    pseq_state_t nxt;

    // Next-state and datapath control decode.
    always_comb begin
        nxt      = state;
        cnt_clr  = 1'b0;
        cnt_inc  = 1'b0;
        lvl_clr  = 1'b0;
        lvl_fill = 1'b0;
        lvl_up   = 1'b0;
        lvl_dn   = 1'b0;
        case (state)
            PS_OFF: begin
                cnt_clr = 1'b1;
                lvl_clr = 1'b1;
                if (!pwr_down)
                    nxt = slow_mode ? PS_HOLD : PS_FAST;
            end
            PS_FAST: begin
                if (pwr_down)
                    nxt = PS_OFF;
                else begin
                    cnt_inc = 1'b1;
                    if (cnt == FAST_LAST) begin
                        nxt      = PS_RUN;
                        lvl_fill = 1'b1;
                    end
                end
            end
            PS_HOLD: begin
                if (pwr_down)
                    nxt = PS_OFF;
                else if (lr_tick) begin
                    cnt_inc = 1'b1;
                    if (cnt == CLAMP_LAST)
                        nxt = PS_RISE;
                end
            end
            PS_RISE: begin
                if (pwr_down)
                    nxt = (level == '0) ? PS_OFF : PS_FALL;
                else if (lr_tick) begin
                    lvl_up = 1'b1;
                    if (level == LVL_PEN)
                        nxt = PS_RUN;
                end
            end
            PS_RUN: begin
                if (pwr_down)
                    nxt = PS_FALL;
            end
            PS_FALL: begin
                if (level == '0)
                    nxt = PS_OFF;
                else if (lr_tick) begin
                    lvl_dn = 1'b1;
                    if (level == LVL_ONE)
                        nxt = PS_OFF;
                end
            end
            default: nxt = PS_OFF;
        endcase
    end

    // State register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= PS_OFF;
        else
            state <= nxt;
    end
endmodule

// File: rtl/dac_popsafe_seq.sv
// Top of the anti-pop power sequencer: state machine, shared event counter
// and level ramp. Outputs are decoded from registered state only.
// Assumes: lr_tick is synchronous to clk and one cycle wide.
module dac_popsafe_seq
    import popseq_pkg::*;
#(
    parameter int CLK_KHZ     = 2000,
    parameter int FAST_US     = 50,
    parameter int CLAMP_TICKS = 1000,
    parameter int RAMP_W      = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_down,
    input  logic              slow_mode,
    input  logic              lr_tick,
    output logic              clamp_en,
    output logic [RAMP_W-1:0] ramp_code,
    output logic              audio_en,
    output logic              ready
);
    localparam int FAST_CYC = (CLK_KHZ * FAST_US) / 1000;
    localparam int CNT_MAX  = (FAST_CYC > CLAMP_TICKS) ? FAST_CYC : CLAMP_TICKS;
    localparam int CNT_W    = $clog2(CNT_MAX + 1);

    pseq_state_t       state;
    logic [CNT_W-1:0]  cnt;
    logic              cnt_clr, cnt_inc;
    logic              lvl_clr, lvl_fill, lvl_up, lvl_dn;

    popseq_fsm #(
        .CNT_W      (CNT_W),
        .RAMP_W     (RAMP_W),
        .FAST_CYC   (FAST_CYC),
        .CLAMP_TICKS(CLAMP_TICKS)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .pwr_down (pwr_down),
        .slow_mode(slow_mode),
        .lr_tick  (lr_tick),
        .cnt      (cnt),
        .level    (ramp_code),
        .cnt_clr  (cnt_clr),
        .cnt_inc  (cnt_inc),
        .lvl_clr  (lvl_clr),
        .lvl_fill (lvl_fill),
        .lvl_up   (lvl_up),
        .lvl_dn   (lvl_dn),
        .state    (state)
    );

    popseq_evcount #(.W(CNT_W)) u_cnt (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (cnt_clr),
        .inc  (cnt_inc),
        .count(cnt)
    );

    popseq_ramp #(.W(RAMP_W)) u_ramp (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (lvl_clr),
        .fill (lvl_fill),
        .up   (lvl_up),
        .dn   (lvl_dn),
        .level(ramp_code)
    );

    // Output decode from the registered state.
    always_comb begin
        clamp_en = (state == PS_OFF) || (state == PS_FAST) || (state == PS_HOLD);
        audio_en = (state == PS_RUN);
        ready    = (state == PS_OFF) || (state == PS_RUN);
    end
endmodule

// File: rtl/popseq_chk.sv
// Property checker for the anti-pop sequencer, attached by bind.
// Assumes: reset is held for at least one edge before checks are armed.
module popseq_chk #(
    parameter int RAMP_W = 14
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pwr_down,
    input logic              lr_tick,
    input logic              clamp_en,
    input logic [RAMP_W-1:0] ramp_code,
    input logic              audio_en,
    input logic              ready
);
    localparam logic [RAMP_W-1:0] LVL_TOP = '1;

    logic armed;

    // Arm the checks one edge after reset is released.
    always_ff @(posedge clk) begin
        if (!rst_n)
            armed <= 1'b0;
        else
            armed <= 1'b1;
    end

    AST_AUDIO_AT_FULL: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        audio_en |-> (!clamp_en && ramp_code == LVL_TOP)); // R9

    AST_CLAMP_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        clamp_en |-> (ramp_code == '0)); // R6

    AST_READY_SETTLED: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        ready |-> (clamp_en || audio_en)); // R9

    AST_RAMP_UNIT_STEP: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        (ramp_code != $past(ramp_code)) |->
            (($past(lr_tick) &&
              (ramp_code == RAMP_W'($past(ramp_code) + RAMP_W'(1)) ||
               ramp_code == RAMP_W'($past(ramp_code) - RAMP_W'(1)))) ||
             ($past(ramp_code) == '0 && ramp_code == LVL_TOP))); // R5

    AST_PDN_MUTES: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        pwr_down |=> !audio_en); // R6

    AST_PDN_NO_CLIMB: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        (pwr_down && !clamp_en) |=> (ramp_code <= $past(ramp_code))); // R8
endmodule

bind dac_popsafe_seq popseq_chk #(.RAMP_W(RAMP_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .pwr_down (pwr_down),
    .lr_tick  (lr_tick),
    .clamp_en (clamp_en),
    .ramp_code(ramp_code),
    .audio_en (audio_en),
    .ready    (ready)
);

// File: tb/sim_dac_popsafe_seq.sv
module sim_dac_popsafe_seq;
    localparam int CLK_KHZ     = 2000;
    localparam int FAST_US     = 50;
    localparam int CLAMP_TICKS = 1000;
    localparam int RAMP_W      = 14;
    localparam int FAST_CYC    = (CLK_KHZ * FAST_US) / 1000;
    localparam int LVL_MAX     = (1 << RAMP_W) - 1;
    localparam int LOOP_CAP    = 40000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              pwr_down = 1'b1;
    logic              slow_mode = 1'b1;
    logic              lr_tick = 1'b0;
    logic              clamp_en, audio_en, ready;
    logic [RAMP_W-1:0] ramp_code;

    int  n_cmp = 0;
    int  n_bad = 0;
    bit  ph = 1'b0;
    bit  done = 1'b0;

    dac_popsafe_seq #(
        .CLK_KHZ(CLK_KHZ), .FAST_US(FAST_US),
        .CLAMP_TICKS(CLAMP_TICKS), .RAMP_W(RAMP_W)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .pwr_down(pwr_down), .slow_mode(slow_mode),
        .lr_tick(lr_tick), .clamp_en(clamp_en), .ramp_code(ramp_code),
        .audio_en(audio_en), .ready(ready)
    );

    always #2 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // One clock: drive tick, pass the edge, settle 1 ns after it.
    task automatic cyc(input bit tk);
        lr_tick = tk;
        @(posedge clk);
        #1;
    endtask

    // One clock with a strobe on every other cycle; returns whether it ticked.
    task automatic step(output bit tk);
        ph = ~ph;
        tk = ph;
        cyc(tk);
    endtask

    task automatic t_reset();
        rst_n = 1'b0; pwr_down = 1'b1;
        repeat (3) cyc(1'b0);
        chk(clamp_en && ramp_code == 0 && !audio_en && ready, "R1 reset state",
            {clamp_en, audio_en, ready}, 3'b101);
        rst_n = 1'b1;
    endtask

    task automatic t_idle();
        int bad = 0;
        bit tk;
        pwr_down = 1'b1;
        for (int i = 0; i < 50; i++) begin
            step(tk);
            if (!(clamp_en && ramp_code == 0 && ready && !audio_en)) bad++;
        end
        chk(bad == 0, "R2 off while power-down set", bad, 0);
    endtask

    task automatic t_fast();
        int n = 0;
        int bad = 0;
        slow_mode = 1'b0; pwr_down = 1'b0;
        while (!audio_en && n < LOOP_CAP) begin
            cyc(1'b0);
            n++;
            if (!audio_en && !(clamp_en && ramp_code == 0 && !ready)) bad++;
        end
        chk(n == FAST_CYC + 1, "R3 fast delay edges", n, FAST_CYC + 1);
        chk(bad == 0, "R3 clamp held at zero during wait", bad, 0);
        chk(ramp_code == LVL_MAX && !clamp_en && ready, "R3 full level at release",
            ramp_code, LVL_MAX);
        // Reset from the running state
        rst_n = 1'b0;
        cyc(1'b0);
        chk(clamp_en && ramp_code == 0 && !audio_en && ready, "R1 reset from run",
            ramp_code, 0);
        pwr_down = 1'b1;
        rst_n = 1'b1;
        cyc(1'b0);
    endtask

    task automatic t_fast_abort();
        int bad = 0;
        slow_mode = 1'b0; pwr_down = 1'b0;
        repeat (10) cyc(1'b0);
        pwr_down = 1'b1;
        cyc(1'b0);
        chk(ready && clamp_en && !audio_en, "R7 abort fast wait to off",
            {ready, clamp_en}, 2'b11);
        for (int i = 0; i < FAST_CYC + 20; i++) begin
            cyc(1'b0);
            if (audio_en || !clamp_en) bad++;
        end
        chk(bad == 0, "R7 stays off after fast abort", bad, 0);
    endtask

    task automatic t_slow_full();
        int ticks = 0;
        int rt = 0;
        int dt = 0;
        int bad = 0;
        int n = 0;
        bit tk;
        slow_mode = 1'b1; pwr_down = 1'b0;
        ph = 1'b0;
        cyc(1'b0);
        chk(!ready && clamp_en, "R4 enter clamp hold", ready, 0);
        while (clamp_en && n < LOOP_CAP) begin
            step(tk);
            n++;
            if (tk) ticks++;
            if (ticks == 10) slow_mode = 1'b0;
            if (audio_en || ready) bad++;
        end
        chk(ticks == CLAMP_TICKS, "R4 clamp hold ticks", ticks, CLAMP_TICKS);
        chk(ramp_code == 0, "R4 level zero at clamp release", ramp_code, 0);
        chk(bad == 0, "R9 muted and busy during hold", bad, 0);
        bad = 0; n = 0;
        while (!audio_en && n < LOOP_CAP) begin
            step(tk);
            n++;
            if (tk) rt++;
            if (int'(ramp_code) != rt) bad++;
            if (!audio_en && ready) bad++;
        end
        chk(rt == LVL_MAX, "R5 rise ticks to full", rt, LVL_MAX);
        chk(bad == 0, "R5 one step per tick", bad, 0);
        chk(ready && ramp_code == LVL_MAX, "R11 slow path kept after mode change",
            ramp_code, LVL_MAX);
        pwr_down = 1'b1;
        cyc(1'b0);
        chk(!audio_en && ramp_code == LVL_MAX && !ready, "R6 mute and hold on power-down",
            audio_en, 0);
        bad = 0; n = 0;
        while (!clamp_en && n < LOOP_CAP) begin
            step(tk);
            n++;
            if (tk) dt++;
            if (int'(ramp_code) != LVL_MAX - dt) bad++;
        end
        chk(dt == LVL_MAX, "R6 descent ticks", dt, LVL_MAX);
        chk(bad == 0, "R6 one step down per tick", bad, 0);
        chk(ready && ramp_code == 0, "R6 clamp back at zero", ramp_code, 0);
    endtask

    task automatic t_hold_race();
        int ticks = 0;
        int bad = 0;
        bit tk;
        slow_mode = 1'b1; pwr_down = 1'b0;
        ph = 1'b0;
        cyc(1'b0);
        while (ticks < CLAMP_TICKS - 1) begin
            step(tk);
            if (tk) ticks++;
        end
        pwr_down = 1'b1;
        cyc(1'b1);
        chk(ready && clamp_en && ramp_code == 0, "R8 power-down beats final hold tick",
            ramp_code, 0);
        for (int i = 0; i < 20; i++) begin
            step(tk);
            if (!clamp_en || ramp_code != 0) bad++;
        end
        chk(bad == 0, "R2 off after hold race", bad, 0);
    endtask

    task automatic t_rise_race();
        int ticks = 0;
        int dt = 0;
        int n = 0;
        bit tk;
        slow_mode = 1'b1; pwr_down = 1'b0;
        ph = 1'b0;
        cyc(1'b0);
        while (clamp_en && n < LOOP_CAP) begin
            step(tk);
            n++;
        end
        while (ticks < 50) begin
            step(tk);
            if (tk) ticks++;
        end
        chk(ramp_code == 50, "R5 partial rise level", ramp_code, 50);
        pwr_down = 1'b1;
        cyc(1'b1);
        chk(ramp_code == 50 && !audio_en && !ready, "R8 power-down beats rise tick",
            ramp_code, 50);
        pwr_down = 1'b0;
        n = 0;
        while (!ready && n < LOOP_CAP) begin
            step(tk);
            n++;
            if (tk) dt++;
        end
        chk(dt == 50 && ramp_code == 0 && clamp_en, "R10 descent completes after bit clears",
            dt, 50);
        cyc(1'b0);
        chk(!ready && clamp_en, "R10 restart into clamp hold", ready, 0);
        pwr_down = 1'b1;
        cyc(1'b0);
        chk(ready && clamp_en, "R7 abort hold to off", ready, 1);
    endtask

    initial begin
        #(4 * 190000);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_idle();
        t_fast();
        t_fast_abort();
        t_slow_full();
        t_hold_race();
        t_rise_race();
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule